// File: doc/BRIEF.md
# Four-Setting 2x2 Switching Element

A two-port steering cell for building multistage interconnection networks. Messages enter on an upper and a lower input, each a valid/data pair. They leave on an upper and a lower output after one register stage. In configured mode, a per-cycle two-bit setting picks one of four routings: pass-through, crossed paths, the upper input copied to both outputs, or the lower input copied to both outputs.

In routing mode the element ignores the setting and steers each message by itself. It reads one bit of the destination field carried in the message word. A 0 in that bit selects the upper output and a 1 selects the lower output. A network of log2(N) stages is formed by giving each stage's instance a different `STAGE` value, where stage 0 uses the most significant destination bit. When two valid messages ask for the same output, the upper one is delivered, the lower one is discarded, and a conflict pulse comes out in the same cycle as the delivered message.

Top module: `sw2_elem`

## Requirements
- R1: While `rst_ni` is low, both output valids, both output data words and `conflict_o` are 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge, and nothing earlier or later. Changing the inputs between edges does not change any output.
- R3: With `route_en_i`=0 and `setting_i`=2'b00 (straight), the upper output carries the upper input and the lower output carries the lower input, valid and data alike.
- R4: With `route_en_i`=0 and `setting_i`=2'b01 (exchange), the upper output carries the lower input and the lower output carries the upper input.
- R5: With `route_en_i`=0 and `setting_i`=2'b10 (upper broadcast), both outputs carry the upper input, and the lower input is dropped.
- R6: With `route_en_i`=0 and `setting_i`=2'b11 (lower broadcast), both outputs carry the lower input, and the upper input is dropped.
- R7: An output's valid is 1 only when a valid input is routed to it. While an output's valid is 0, its data is all zeros.
- R8: With `route_en_i`=1, each valid input goes to the upper output when the selected bit is 0 and to the lower output when it is 1. The selected bit is data bit DEST_LSB+DEST_W-1-STAGE, which is bit 7 at the defaults DATA_W=8, DEST_W=3, DEST_LSB=5, STAGE=0. `setting_i` has no effect in this mode.
- R9: In routing mode, two valid inputs with different selected bits are both delivered in the same cycle, and no conflict is flagged.
- R10: In routing mode, two valid inputs with equal selected bits cause three things. The upper message goes out on the requested output, the other output is not valid, and `conflict_o` is 1 for that one output cycle.
- R11: `conflict_o` is 0 in configured mode, and in routing mode whenever fewer than two inputs are valid or their selected bits differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| route_en_i | input | 1 | 1: steer by destination bit; 0: use `setting_i` |
| setting_i | input | 2 | 00 straight, 01 exchange, 10 upper broadcast, 11 lower broadcast |
| up_valid_i | input | 1 | Upper input message present |
| up_data_i | input | DATA_W | Upper input message word |
| lo_valid_i | input | 1 | Lower input message present |
| lo_data_i | input | DATA_W | Lower input message word |
| up_valid_o | output | 1 | Upper output message present |
| up_data_o | output | DATA_W | Upper output message word |
| lo_valid_o | output | 1 | Lower output message present |
| lo_data_o | output | DATA_W | Lower output message word |
| conflict_o | output | 1 | Both inputs requested the same output; lower message dropped |

## Verification
Every result, including the two valids, both data words and the conflict pulse, is due exactly one rising edge after its inputs are sampled. The bench drives each vector on a falling edge. It first checks that the outputs still show the previous vector's expected values two nanoseconds after the change, which catches any combinational leak. It then checks the new vector's expected values at the next falling edge, one edge later. The sweep covers both modes, all four settings, all four valid combinations, and every pair of three-bit destinations. Expected values are derived arithmetically from the requirement rules.

// File: rtl/sw2_pkg.sv
package sw2_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned SET_W     = 2;

  typedef enum logic [SET_W-1:0] {
    SET_STRAIGHT = 2'b00,
    SET_EXCHANGE = 2'b01,
    SET_BCAST_UP = 2'b10,
    SET_BCAST_LO = 2'b11
  } sw_setting_e;

  // port index: 0 = upper, 1 = lower
  localparam int unsigned PORT_UP = 0;
  localparam int unsigned PORT_LO = 1;
endpackage

// File: rtl/sw2_route_dec.sv
module sw2_route_dec
  import sw2_pkg::*;
(
  input  logic                 route_en_i,
  input  sw_setting_e          setting_i,
  input  logic                 up_valid_i,
  input  logic                 up_req_i,
  input  logic                 lo_valid_i,
  input  logic                 lo_req_i,
  output logic [NUM_PORTS-1:0] src_lo_o,
  output logic [NUM_PORTS-1:0] src_en_o,
  output logic                 conflict_o
);

  always_comb begin
    src_lo_o   = '0;
    src_en_o   = '0;
    conflict_o = 1'b0;
    if (route_en_i) begin
      for (int k = 0; k < NUM_PORTS; k++) begin
        if (up_valid_i && (up_req_i == k[0])) begin
          src_en_o[k] = 1'b1;
          src_lo_o[k] = 1'b0;
        end else if (lo_valid_i && (lo_req_i == k[0])) begin
          src_en_o[k] = 1'b1;
          src_lo_o[k] = 1'b1;
        end
      end
      conflict_o = up_valid_i && lo_valid_i && (up_req_i == lo_req_i);
    end else begin
      unique case (setting_i)
        SET_STRAIGHT: begin
          src_lo_o = 2'b10;
          src_en_o = {lo_valid_i, up_valid_i};
        end
        SET_EXCHANGE: begin
          src_lo_o = 2'b01;
          src_en_o = {up_valid_i, lo_valid_i};
        end
        SET_BCAST_UP: begin
          src_lo_o = 2'b00;
          src_en_o = {up_valid_i, up_valid_i};
        end
        SET_BCAST_LO: begin
          src_lo_o = 2'b11;
          src_en_o = {lo_valid_i, lo_valid_i};
        end
        default: begin
          src_lo_o = '0;
          src_en_o = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sw2_xbar.sv
module sw2_xbar
  import sw2_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [NUM_PORTS-1:0]             src_lo_i,
  input  logic [NUM_PORTS-1:0]             src_en_i,
  input  logic [DATA_W-1:0]                up_data_i,
  input  logic [DATA_W-1:0]                lo_data_i,
  output logic [NUM_PORTS-1:0]             valid_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] data_o
);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_out
    assign valid_o[g] = src_en_i[g];
    // idle outputs carry zeros
    assign data_o[g]  = !src_en_i[g] ? '0 :
                        (src_lo_i[g] ? lo_data_i : up_data_i);
  end

endmodule

// File: rtl/sw2_out_reg.sv
module sw2_out_reg
  import sw2_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PORTS-1:0]             valid_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] data_i,
  input  logic                             conflict_i,
  output logic [NUM_PORTS-1:0]             valid_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] data_o,
  output logic                             conflict_o
);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        data_o[g]  <= '0;
      end else begin
        valid_o[g] <= valid_i[g];
        data_o[g]  <= data_i[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conflict_o <= 1'b0;
    else         conflict_o <= conflict_i;
  end

endmodule

// File: rtl/sw2_elem.sv
module sw2_elem
  import sw2_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEST_W   = 3,
  parameter int unsigned DEST_LSB = 5,
  parameter int unsigned STAGE    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              route_en_i,
  input  logic [1:0]        setting_i,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              lo_valid_i,
  input  logic [DATA_W-1:0] lo_data_i,
  output logic              up_valid_o,
  output logic [DATA_W-1:0] up_data_o,
  output logic              lo_valid_o,
  output logic [DATA_W-1:0] lo_data_o,
  output logic              conflict_o
);

  // stage 0 steers on the destination MSB
  localparam int unsigned SEL_POS = DEST_LSB + DEST_W - 1 - STAGE;

  logic [NUM_PORTS-1:0]             src_lo, src_en;
  logic                             conflict_d;
  logic [NUM_PORTS-1:0]             nxt_valid, q_valid;
  logic [NUM_PORTS-1:0][DATA_W-1:0] nxt_data, q_data;

  sw2_route_dec u_dec (
    .route_en_i (route_en_i),
    .setting_i  (sw_setting_e'(setting_i)),
    .up_valid_i (up_valid_i),
    .up_req_i   (up_data_i[SEL_POS]),
    .lo_valid_i (lo_valid_i),
    .lo_req_i   (lo_data_i[SEL_POS]),
    .src_lo_o   (src_lo),
    .src_en_o   (src_en),
    .conflict_o (conflict_d)
  );

  sw2_xbar #(.DATA_W(DATA_W)) u_xbar (
    .src_lo_i  (src_lo),
    .src_en_i  (src_en),
    .up_data_i (up_data_i),
    .lo_data_i (lo_data_i),
    .valid_o   (nxt_valid),
    .data_o    (nxt_data)
  );

  sw2_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (nxt_valid),
    .data_i     (nxt_data),
    .conflict_i (conflict_d),
    .valid_o    (q_valid),
    .data_o     (q_data),
    .conflict_o (conflict_o)
  );

  assign up_valid_o = q_valid[PORT_UP];
  assign up_data_o  = q_data[PORT_UP];
  assign lo_valid_o = q_valid[PORT_LO];
  assign lo_data_o  = q_data[PORT_LO];

endmodule

// File: rtl/sw2_elem_chk.sv
module sw2_elem_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_POS = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              route_en_i,
  input logic [1:0]        setting_i,
  input logic              up_valid_i,
  input logic [DATA_W-1:0] up_data_i,
  input logic              lo_valid_i,
  input logic [DATA_W-1:0] lo_data_i,
  input logic              up_valid_o,
  input logic [DATA_W-1:0] up_data_o,
  input logic              lo_valid_o,
  input logic [DATA_W-1:0] lo_data_o,
  input logic              conflict_o
);

  AST_STRAIGHT_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!route_en_i && setting_i == 2'b00) |=>
      (up_valid_o == $past(up_valid_i)) && (lo_valid_o == $past(lo_valid_i)) &&
      (!up_valid_o || up_data_o == $past(up_data_i)) &&
      (!lo_valid_o || lo_data_o == $past(lo_data_i))); // R3

  AST_EXCHANGE_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!route_en_i && setting_i == 2'b01) |=>
      (up_valid_o == $past(lo_valid_i)) && (lo_valid_o == $past(up_valid_i)) &&
      (!up_valid_o || up_data_o == $past(lo_data_i)) &&
      (!lo_valid_o || lo_data_o == $past(up_data_i))); // R4

  AST_BCAST_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!route_en_i && setting_i == 2'b10) |=>
      (up_valid_o == $past(up_valid_i)) && (lo_valid_o == $past(up_valid_i)) &&
      (up_data_o == lo_data_o)); // R5

  AST_BCAST_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!route_en_i && setting_i == 2'b11) |=>
      (up_valid_o == $past(lo_valid_i)) && (lo_valid_o == $past(lo_valid_i)) &&
      (up_data_o == lo_data_o)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_valid_o |-> up_data_o == '0) and (!lo_valid_o |-> lo_data_o == '0)); // R7

  AST_ROUTE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_en_i && up_valid_i && lo_valid_i && (up_data_i[SEL_POS] != lo_data_i[SEL_POS])) |=>
      up_valid_o && lo_valid_o && !conflict_o); // R9

  AST_CONFLICT_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_en_i && up_valid_i && lo_valid_i && (up_data_i[SEL_POS] == lo_data_i[SEL_POS])) |=>
      conflict_o && $onehot({up_valid_o, lo_valid_o}) &&
      (($past(up_data_i[SEL_POS]) ? lo_data_o : up_data_o) == $past(up_data_i))); // R10

  AST_NO_FALSE_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(route_en_i && up_valid_i && lo_valid_i) |=> !conflict_o); // R11

endmodule

bind sw2_elem sw2_elem_chk #(.DATA_W(DATA_W), .SEL_POS(SEL_POS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .route_en_i (route_en_i),
  .setting_i  (setting_i),
  .up_valid_i (up_valid_i),
  .up_data_i  (up_data_i),
  .lo_valid_i (lo_valid_i),
  .lo_data_i  (lo_data_i),
  .up_valid_o (up_valid_o),
  .up_data_o  (up_data_o),
  .lo_valid_o (lo_valid_o),
  .lo_data_o  (lo_data_o),
  .conflict_o (conflict_o)
);

// File: tb/tb_sw2_elem.sv
`timescale 1ns/1ps
module tb_sw2_elem;
  localparam int DW = 8;
  localparam int SEL = 7;
  localparam int RW = 2*DW + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          route_en = 1'b0;
  logic [1:0]    setting = '0;
  logic          uv = 1'b0, lv = 1'b0;
  logic [DW-1:0] ud = '0, ld = '0;
  logic          uvo, lvo, cfo;
  logic [DW-1:0] udo, ldo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sw2_elem dut (
    .clk_i(clk), .rst_ni(rst_n), .route_en_i(route_en), .setting_i(setting),
    .up_valid_i(uv), .up_data_i(ud), .lo_valid_i(lv), .lo_data_i(ld),
    .up_valid_o(uvo), .up_data_o(udo), .lo_valid_o(lvo), .lo_data_o(ldo),
    .conflict_o(cfo)
  );

  // packed result: {conflict, up_valid, up_data, lo_valid, lo_data}
  function automatic logic [RW-1:0] model(input logic r, input logic [1:0] s,
                                          input logic a_v, input logic [DW-1:0] a_d,
                                          input logic b_v, input logic [DW-1:0] b_d);
    logic o0v, o1v, cf;
    logic [DW-1:0] o0d, o1d;
    int a_req, b_req;
    o0v = 0; o1v = 0; cf = 0; o0d = '0; o1d = '0;
    a_req = (a_d >> SEL) & 1;
    b_req = (b_d >> SEL) & 1;
    if (r) begin
      if (a_v && a_req == 0) begin o0v = 1; o0d = a_d; end
      else if (b_v && b_req == 0) begin o0v = 1; o0d = b_d; end
      if (a_v && a_req == 1) begin o1v = 1; o1d = a_d; end
      else if (b_v && b_req == 1) begin o1v = 1; o1d = b_d; end
      cf = a_v && b_v && (a_req == b_req);
    end else begin
      case (s)
        2'd0: begin o0v = a_v; o0d = a_d; o1v = b_v; o1d = b_d; end
        2'd1: begin o0v = b_v; o0d = b_d; o1v = a_v; o1d = a_d; end
        2'd2: begin o0v = a_v; o0d = a_d; o1v = a_v; o1d = a_d; end
        default: begin o0v = b_v; o0d = b_d; o1v = b_v; o1d = b_d; end
      endcase
      if (!o0v) o0d = '0;
      if (!o1v) o1d = '0;
    end
    return {cf, o0v, o0d, o1v, o1d};
  endfunction

  task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] outs();
    return {cfo, uvo, udo, lvo, ldo};
  endfunction

  function automatic string tag(input logic r, input logic [1:0] s, input logic [RW-1:0] e);
    if (r) return e[RW-1] ? "R10" : ((e[2*DW+1] && e[DW]) ? "R9" : "R8");
    case (s)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2: watchdog expired, actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] exp_prev;
    logic [RW-1:0] exp_cur;
    int seq;
    // R1: reset with active inputs
    uv = 1; lv = 1; ud = 8'hA5; ld = 8'h3C; route_en = 1;
    repeat (3) @(negedge clk);
    chk("R1", outs(), '0);
    uv = 0; lv = 0; route_en = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_prev = '0;
    chk("R1", outs(), exp_prev);
    seq = 0;
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 4; s++)
        for (int m = 0; m < 4; m++)
          for (int da = 0; da < 8; da++)
            for (int db = 0; db < 8; db++) begin
              seq++;
              route_en = r[0];
              setting  = s[1:0];
              uv = m[0];
              lv = m[1];
              ud = {da[2:0], 5'((seq * 7 + 3) & 31)};
              ld = {db[2:0], 5'((seq * 13 + 9) & 31)};
              exp_cur = model(r[0], s[1:0], m[0], ud, m[1], ld);
              #2;
              chk("R2", outs(), exp_prev);
              @(negedge clk);
              chk(tag(r[0], s[1:0], exp_cur), outs(), exp_cur);
              if (!exp_cur[2*DW+1] || !exp_cur[DW])
                chk("R7", {udo & {DW{uvo}}, ldo & {DW{lvo}}, udo, ldo},
                          {udo & {DW{uvo}}, ldo & {DW{lvo}}, udo & {DW{uvo}}, ldo & {DW{lvo}}});
              if (!exp_cur[RW-1])
                chk("R11", {{(RW-1){1'b0}}, cfo}, '0);
              exp_prev = exp_cur;
            end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule